// File: doc/BRIEF.md
# Two-Bank GPIO Controller with Edge Events

The block is a general-purpose I/O controller. Its pins are split into a low "core" bank and a high "resume" bank, and the split index is a parameter. Software reaches every pin through a byte-wide register port. For each pin it can set an enable bit, a direction bit, an output level, separate rising-edge and falling-edge detect enables, an event enable and one spare routing bit. It can also read back the pad and clear latched edge status.

Pad inputs pass through a two-flop synchronizer before edge detection. A qualifying edge on an enabled pin sets a sticky status bit, and software clears that bit by writing a one to it. One level-sensitive event output stays high while any latched status bit in either bank has its event enable set. The pad side of the block is three vectors: input, output and output enable.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Address bit 5 selects the bank (0 core, 1 resume). Address bits 4:2 select the register: 0 enable, 1 direction, 2 level, 3 rising enable, 4 falling enable, 5 event enable, 6 spare routing, 7 status. Address bits 1:0 select the byte. Pin p maps to bank-local index L, which is p below the split parameter SPLIT and p-SPLIT at or above it. Pin p is then bit L%8 of byte L/8.
- R2: After reset every pin is an input (direction 1). Level, edge enables, event enables, spare bits and status are 0. The pin enables take the parameter EN_RESET, which by default clears pins 8, 9 and 13 of 14 pins split at 10.
- R3: pad_oe of a pin is high exactly when it is enabled and its direction bit is 0. pad_out carries the stored level bit.
- R4: A write to a pin's level bit is ignored while that pin's direction bit is 1. Reading the level register returns the synchronized pad for input pins and the stored level for output pins.
- R5: A rising pad edge on an enabled pin with its rising enable set makes its status bit read 1 after the third clock edge following the pad change.
- R6: The falling enable works independently of the rising enable. With both set, either edge sets status, and a pin with neither set never latches.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R8: When a new edge and a clearing write reach the same status bit in the same cycle, the bit stays set.
- R9: event_irq is high exactly when some status bit in either bank is set together with its event-enable bit.
- R10: A disabled pin never sets its status bit and never drives pad_oe.
- R11: The spare routing register reads back what was written and has no other effect.
- R12: Bits and bytes that map to no pin read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 6 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per byte written |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pad_in | input | NUM_PINS | Pad input levels, asynchronous |
| pad_out | output | NUM_PINS | Pad output levels |
| pad_oe | output | NUM_PINS | Pad output enables |
| event_irq | output | 1 | Level-sensitive event request |

## Verification
The hardest case to reach is the cycle in which a freshly detected edge and a software clear land on the same status bit. The bench changes the pad on a falling clock edge and counts two rising edges through the synchronizer. It then issues the clearing write so that the write is active on the third edge, the one that latches the new event. A behavioural model, kept as plain arrays and updated every clock, predicts pad_oe, pad_out, event_irq and every read. Directed reads with fixed values also cover the bank split, the disabled pins and the input-locked level bits.

// File: rtl/gpio_bank_pkg.sv
// Shared definitions for the two-bank GPIO controller.
// Assumes each bank holds at most 32 pins (four bytes per register).
package gpio_bank_pkg;

    typedef enum logic [2:0] {
        REG_EN   = 3'd0,
        REG_DIR  = 3'd1,
        REG_LVL  = 3'd2,
        REG_RISE = 3'd3,
        REG_FALL = 3'd4,
        REG_EVT  = 3'd5,
        REG_ROUT = 3'd6,
        REG_STAT = 3'd7
    } gpio_reg_e;

    localparam int ADDR_W = 6;
    localparam int BYTE_W = 8;

    // Bank of a global pin: 0 core, 1 resume.
    function automatic int pin_bank(input int p, input int split);
        return (p >= split) ? 1 : 0;
    endfunction

    // Bank-local index of a global pin.
    function automatic int pin_local(input int p, input int split);
        return (p >= split) ? (p - split) : p;
    endfunction

endpackage

// File: rtl/gpio_edge_sync.sv
// Two-flop synchronizer with one history flop per pin.
// Produces the synchronized level and single-cycle rise/fall pulses.
// Assumes pad inputs are asynchronous to clk.
module gpio_edge_sync #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] hist_q;

    // Synchronize pads and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign sync_o = sync_q;
    assign rise_o = sync_q & ~hist_q;
    assign fall_o = ~sync_q & hist_q;
endmodule

// File: rtl/gpio_cfg_regs.sv
// Per-pin configuration storage and write decode.
// Each pin decodes its own bank and byte select from the address.
// A level write is accepted only while the pin is an output.
// Assumes one byte is written per bus_wr cycle.
module gpio_cfg_regs
    import gpio_bank_pkg::*;
#(
    parameter int                 NUM_PINS = 14,
    parameter int                 SPLIT    = 10,
    parameter logic [NUM_PINS-1:0] EN_RESET = 14'h1CFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [NUM_PINS-1:0] pin_sel,
    output logic [NUM_PINS-1:0] en_q,
    output logic [NUM_PINS-1:0] dir_q,
    output logic [NUM_PINS-1:0] lvl_q,
    output logic [NUM_PINS-1:0] rise_en_q,
    output logic [NUM_PINS-1:0] fall_en_q,
    output logic [NUM_PINS-1:0] evt_en_q,
    output logic [NUM_PINS-1:0] rout_q,
    output logic [NUM_PINS-1:0] stat_clr
);
    gpio_reg_e reg_sel;
    assign reg_sel = gpio_reg_e'(bus_addr[4:2]);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int BANK = pin_bank(p, SPLIT);
        localparam int LOC  = pin_local(p, SPLIT);
        localparam int BYT  = LOC / 8;
        localparam int BITP = LOC % 8;

        logic wbit;
        logic hit;
        logic en_b, dir_b, lvl_b, rise_b, fall_b, evt_b, rout_b;

        assign pin_sel[p] = (bus_addr[5] == 1'(BANK)) && (bus_addr[1:0] == 2'(BYT));
        assign wbit       = bus_wdata[BITP];
        assign hit        = bus_wr && pin_sel[p];

        // Update this pin's configuration bits on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_b   <= EN_RESET[p];
                dir_b  <= 1'b1;
                lvl_b  <= 1'b0;
                rise_b <= 1'b0;
                fall_b <= 1'b0;
                evt_b  <= 1'b0;
                rout_b <= 1'b0;
            end else if (hit) begin
                case (reg_sel)
                    REG_EN:   en_b   <= wbit;
                    REG_DIR:  dir_b  <= wbit;
                    REG_LVL:  if (!dir_b) lvl_b <= wbit;
                    REG_RISE: rise_b <= wbit;
                    REG_FALL: fall_b <= wbit;
                    REG_EVT:  evt_b  <= wbit;
                    REG_ROUT: rout_b <= wbit;
                    default:  ;
                endcase
            end
        end

        assign en_q[p]      = en_b;
        assign dir_q[p]     = dir_b;
        assign lvl_q[p]     = lvl_b;
        assign rise_en_q[p] = rise_b;
        assign fall_en_q[p] = fall_b;
        assign evt_en_q[p]  = evt_b;
        assign rout_q[p]    = rout_b;
        assign stat_clr[p]  = hit && (reg_sel == REG_STAT) && wbit;
    end
endmodule

// File: rtl/gpio_evt_status.sv
// Sticky edge status with write-one-to-clear and the merged event output.
// A new edge wins over a clear in the same cycle.
// Assumes rise/fall inputs are single-cycle pulses from the synchronizer.
module gpio_evt_status #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] en,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic [W-1:0] evt_en,
    input  logic [W-1:0] rise,
    input  logic [W-1:0] fall,
    input  logic [W-1:0] clr,
    output logic [W-1:0] status_q,
    output logic         irq
);
    logic [W-1:0] set_v;

    // Qualify edges with the pin enable and per-polarity enables.
    always_comb begin
        set_v = en & ((rise & rise_en) | (fall & fall_en));
    end

    // Latch events; a set overrides a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr) | set_v;
        end
    end

    assign irq = |(status_q & evt_en);
endmodule

// File: rtl/gpio_bank_ctrl.sv
// Top of the two-bank GPIO controller: synchronizer, per-pin
// configuration, event status and the byte-wide read multiplexer.
// Assumes SPLIT <= 32 and NUM_PINS - SPLIT <= 32.
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int                 NUM_PINS = 14,
    parameter int                 SPLIT    = 10,
    parameter logic [NUM_PINS-1:0] EN_RESET = 14'h1CFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [5:0]          bus_addr,
    input  logic                bus_wr,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                event_irq
);
    logic [NUM_PINS-1:0] sync_v, rise_v, fall_v;
    logic [NUM_PINS-1:0] pin_sel;
    logic [NUM_PINS-1:0] en_q, dir_q, lvl_q, rise_en_q, fall_en_q, evt_en_q, rout_q;
    logic [NUM_PINS-1:0] stat_clr, status_q;

    gpio_edge_sync #(.W(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .sync_o (sync_v),
        .rise_o (rise_v),
        .fall_o (fall_v)
    );

    gpio_cfg_regs #(
        .NUM_PINS (NUM_PINS),
        .SPLIT    (SPLIT),
        .EN_RESET (EN_RESET)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .pin_sel   (pin_sel),
        .en_q      (en_q),
        .dir_q     (dir_q),
        .lvl_q     (lvl_q),
        .rise_en_q (rise_en_q),
        .fall_en_q (fall_en_q),
        .evt_en_q  (evt_en_q),
        .rout_q    (rout_q),
        .stat_clr  (stat_clr)
    );

    gpio_evt_status #(.W(NUM_PINS)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_q),
        .rise_en  (rise_en_q),
        .fall_en  (fall_en_q),
        .evt_en   (evt_en_q),
        .rise     (rise_v),
        .fall     (fall_v),
        .clr      (stat_clr),
        .status_q (status_q),
        .irq      (event_irq)
    );

    assign pad_out = lvl_q;
    assign pad_oe  = en_q & ~dir_q;

    // Assemble the addressed byte from every pin that maps into it.
    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (pin_sel[p]) begin
                case (gpio_reg_e'(bus_addr[4:2]))
                    REG_EN:   bus_rdata[pin_local(p, SPLIT) % 8] = en_q[p];
                    REG_DIR:  bus_rdata[pin_local(p, SPLIT) % 8] = dir_q[p];
                    REG_LVL:  bus_rdata[pin_local(p, SPLIT) % 8] = dir_q[p] ? sync_v[p] : lvl_q[p];
                    REG_RISE: bus_rdata[pin_local(p, SPLIT) % 8] = rise_en_q[p];
                    REG_FALL: bus_rdata[pin_local(p, SPLIT) % 8] = fall_en_q[p];
                    REG_EVT:  bus_rdata[pin_local(p, SPLIT) % 8] = evt_en_q[p];
                    REG_ROUT: bus_rdata[pin_local(p, SPLIT) % 8] = rout_q[p];
                    default:  bus_rdata[pin_local(p, SPLIT) % 8] = status_q[p];
                endcase
            end
        end
    end
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
// Property checker for gpio_bank_ctrl, attached by bind below.
// Observes pad outputs, the bus strobe and the stored pin state.
module gpio_bank_ctrl_chk #(
    parameter int W = 14
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_wr,
    input logic [W-1:0] pad_oe,
    input logic         event_irq,
    input logic [W-1:0] en_q,
    input logic [W-1:0] dir_q,
    input logic [W-1:0] lvl_q,
    input logic [W-1:0] status_q
);
    // R2
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (status_q == '0 && dir_q == '1));

    // R4
    input_level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((lvl_q ^ $past(lvl_q)) & $past(dir_q)) == '0);

    // R7
    status_only_bus_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_wr) |-> ((~status_q & $past(status_q)) == '0));

    // R10
    disabled_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~$past(status_q)) & ~$past(en_q)) == '0);

    // R10
    disabled_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~en_q) == '0);

    // R9
    irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        event_irq |-> (status_q != '0));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.W(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .pad_oe    (pad_oe),
    .event_irq (event_irq),
    .en_q      (en_q),
    .dir_q     (dir_q),
    .lvl_q     (lvl_q),
    .status_q  (status_q)
);

// File: tb/gpio_bank_ctrl_tb.sv
// Self-checking bench: behavioural model updated each clock plus directed reads.
module gpio_bank_ctrl_tb;
    localparam int NP    = 14;
    localparam int SP    = 10;
    localparam logic [NP-1:0] ENR = 14'h1CFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe;
    logic          event_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit run = 0;

    always #4 clk = ~clk;

    gpio_bank_ctrl #(.NUM_PINS(NP), .SPLIT(SP), .EN_RESET(ENR)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .event_irq(event_irq)
    );

    // Model state: m_reg[k] is register k as a pin vector (7 = status).
    logic [NP-1:0] m_reg [8];
    logic [NP-1:0] m_s1, m_s2, m_s3;

    always @(posedge clk) begin
        logic [NP-1:0] nreg [8];
        logic [NP-1:0] setv;
        if (!rst_n) begin
            for (int k = 0; k < 8; k++) m_reg[k] <= '0;
            m_reg[0] <= ENR;
            m_reg[1] <= '1;
            m_s1 <= '0; m_s2 <= '0; m_s3 <= '0;
        end else begin
            for (int k = 0; k < 8; k++) nreg[k] = m_reg[k];
            setv = m_reg[0] & ((m_s2 & ~m_s3 & m_reg[3]) | (~m_s2 & m_s3 & m_reg[4]));
            if (bus_wr) begin
                for (int p = 0; p < NP; p++) begin
                    int b, l, k;
                    b = (p >= SP) ? 1 : 0;
                    l = (p >= SP) ? p - SP : p;
                    k = int'(bus_addr[4:2]);
                    if (int'(bus_addr[5]) == b && int'(bus_addr[1:0]) == l / 8) begin
                        if (k == 7) begin
                            if (bus_wdata[l % 8]) nreg[7][p] = 1'b0;
                        end else if (k == 2) begin
                            if (!m_reg[1][p]) nreg[2][p] = bus_wdata[l % 8];
                        end else begin
                            nreg[k][p] = bus_wdata[l % 8];
                        end
                    end
                end
            end
            nreg[7] = nreg[7] | setv;
            for (int k = 0; k < 8; k++) m_reg[k] <= nreg[k];
            m_s1 <= pad_in; m_s2 <= m_s1; m_s3 <= m_s2;
        end
    end

    function automatic logic [7:0] mread(input logic [5:0] a);
        logic [7:0] r = '0;
        for (int p = 0; p < NP; p++) begin
            int b, l, k;
            b = (p >= SP) ? 1 : 0;
            l = (p >= SP) ? p - SP : p;
            k = int'(a[4:2]);
            if (int'(a[5]) == b && int'(a[1:0]) == l / 8)
                r[l % 8] = (k == 2 && m_reg[1][p]) ? m_s2[p] : m_reg[k][p];
        end
        return r;
    endfunction

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, got, exp, $time);
        end
    endtask

    // Compare pad outputs and the event line against the model every clock.
    always @(negedge clk) begin
        if (run) begin
            chk(32'(pad_oe), 32'(m_reg[0] & ~m_reg[1]), "R3 pad_oe");
            chk(32'(pad_out), 32'(m_reg[2]), "R3 pad_out");
            chk(32'(event_irq), 32'(|(m_reg[7] & m_reg[5])), "R9 event_irq");
        end
    end

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [7:0] exp, input string tag);
        bus_addr = a;
        #1;
        chk(32'(bus_rdata), 32'(exp), tag);
        chk(32'(bus_rdata), 32'(mread(a)), tag);
        @(negedge clk);
    endtask

    task automatic pads(input logic [NP-1:0] v);
        pad_in = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog all requirements actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        run = 1;
        // R2 reset values
        rd(6'h00, 8'hFF, "R2 core enable byte0");
        rd(6'h01, 8'h00, "R2 core enable byte1 pins 8,9 off");
        rd(6'h20, 8'h07, "R2 resume enable pin13 off");
        rd(6'h05, 8'h03, "R2 direction input");
        rd(6'h24, 8'h0F, "R2 resume direction input");
        rd(6'h1C, 8'h00, "R2 core status");
        rd(6'h3C, 8'h00, "R2 resume status");
        // R1 R3 output path
        wr(6'h04, 8'h00);
        wr(6'h08, 8'hA5);
        rd(6'h08, 8'hA5, "R1 level readback");
        chk(32'(pad_oe[7:0]), 32'hFF, "R3 oe outputs");
        chk(32'(pad_out[7:0]), 32'hA5, "R3 out level");
        wr(6'h20, 8'h0F);
        rd(6'h20, 8'h0F, "R1 resume enable pin13");
        // R4 input level behaviour
        pads(14'h0200);
        wr(6'h09, 8'h03);
        rd(6'h09, 8'h02, "R4 level read shows pad for inputs");
        wr(6'h04, 8'h01);
        wr(6'h08, 8'h00);
        chk(32'(pad_out[0]), 32'h1, "R4 level write ignored on input");
        rd(6'h08, 8'h00, "R4 input bit reads pad");
        // R5 R6 edges on resume bank
        wr(6'h2C, 8'h05);
        wr(6'h30, 8'h06);
        pads(14'h3E00);
        rd(6'h3C, 8'h05, "R5 rising edges latched");
        pads(14'h0200);
        rd(6'h3C, 8'h07, "R6 falling edges latched");
        // R9 event gating
        wr(6'h34, 8'h08);
        chk(32'(event_irq), 32'h0, "R9 no enabled event");
        wr(6'h34, 8'h02);
        chk(32'(event_irq), 32'h1, "R9 enabled event");
        // R7 clear
        wr(6'h3C, 8'h00);
        rd(6'h3C, 8'h07, "R7 zero write keeps status");
        wr(6'h3C, 8'h02);
        rd(6'h3C, 8'h05, "R7 one write clears");
        chk(32'(event_irq), 32'h0, "R9 event drops after clear");
        // R8 set wins over same-cycle clear (pin 10)
        pad_in = 14'h0600;
        @(negedge clk);
        @(negedge clk);
        wr(6'h3C, 8'h01);
        rd(6'h3C, 8'h05, "R8 set beats clear");
        wr(6'h3C, 8'h05);
        rd(6'h3C, 8'h00, "R8 later clear works");
        // R9 core bank event
        wr(6'h04, 8'h09);
        wr(6'h0C, 8'h08);
        wr(6'h14, 8'h08);
        pads(14'h0608);
        rd(6'h1C, 8'h08, "R9 core status");
        chk(32'(event_irq), 32'h1, "R9 core event");
        // R10 disabled pin 8
        wr(6'h0D, 8'h01);
        pads(14'h0708);
        rd(6'h1D, 8'h00, "R10 disabled pin no status");
        wr(6'h05, 8'h00);
        chk(32'(pad_oe[9:8]), 32'h0, "R10 disabled pin no drive");
        // R11 spare register
        wr(6'h18, 8'h5A);
        rd(6'h18, 8'h5A, "R11 spare core");
        wr(6'h38, 8'hFF);
        rd(6'h38, 8'h0F, "R11 spare resume");
        // R12 unmapped
        rd(6'h22, 8'h00, "R12 empty resume byte");
        wr(6'h02, 8'hFF);
        rd(6'h02, 8'h00, "R12 empty core byte");
        wr(6'h01, 8'hFF);
        rd(6'h01, 8'h03, "R12 unused bits");
        // R1 full map against model
        for (int a = 0; a < 64; a++) begin
            bus_addr = 6'(a);
            #1;
            chk(32'(bus_rdata), 32'(mread(6'(a))), "R1 map sweep");
            @(negedge clk);
        end
        run = 0;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule